// File: doc/BRIEF.md
# Pipelined shift-add multiply-accumulate

This block computes `a*b + c` on unsigned operands. The product is built by radix-2 shift-and-add. Each set bit `i` of `b` adds a copy of `a` shifted left by `i` positions, and the work is spread over a three-register pipeline.

The first stage adds the lower half of the shifted copies to the addend `c`. The second stage adds the upper half. The third stage registers the finished sum onto the output. The operand `a` and the unused upper bits of `b` travel with the partial sum, so the second stage still has them.

A valid flag goes in with each operand set and moves through the pipeline in step with the data. A new set may be presented on every clock with no stalls.

Top module: `shift_add_mac`

## Requirements
- R1: For every operand set accepted with `inValid` high, `result` equals `a*b + c`, computed as an unsigned value 8 bits wide, with 4-bit unsigned operands at the default width.
- R2: If an operand set is present at rising edge t, its result and `outValid` appear on the outputs after rising edge t+2. That is 3 clock cycles of latency, with no variation.
- R3: Operand sets may be presented on consecutive clocks without gaps. Each one yields its own correct result on consecutive cycles, in the same order it was presented.
- R4: `outValid` is high in a cycle exactly when `inValid` was high 3 clocks earlier. A cycle with `inValid` low yields a cycle with `outValid` low, and the result word is then not meaningful.
- R5: Synchronous reset (`rst` high at a rising edge) clears every stage's valid bit, so `outValid` is low on the cycle after reset.
- R6: The extreme operands come out exact. Setting a=b=c=15 gives 240, all operands zero give 0, and b=0 gives `c`.
- R7: Partial product i contributes `a` shifted left by i exactly when bit i of `b` is 1. With a one-hot `b` = 2^i and c=0, the result is `a << i`.
- R8: A reset asserted while operand sets are in flight discards them. None of those sets ever produces `outValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks a, b, c as an operand set to process |
| a | input | OPW (4) | Multiplicand, unsigned |
| b | input | OPW (4) | Multiplier, unsigned |
| c | input | OPW (4) | Addend, unsigned |
| outValid | output | 1 | Result word holds a finished sum |
| result | output | 2*OPW (8) | a*b + c |

## Verification
Every result and its valid flag are due three rising edges after their operand set is captured. The bench drives each set at a falling edge and keeps the expected flag and value in a four-entry ring indexed by the cycle count. It compares the outputs at each later falling edge against the entry written three cycles before. A reset step clears the whole ring, so sets that were in flight are expected to vanish and `outValid` is expected low one cycle after the reset edge.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Load strobes handed from control to datapath, one per pipeline register
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } stageStrobes_t;

  localparam int STAGES = 3;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output stageStrobes_t strobes,
  output logic          outValid
);
  logic [STAGES-1:0] validQ;

  always_ff @(posedge clk) begin
    if (rst) validQ <= '0;
    else     validQ <= {validQ[STAGES-2:0], inValid};
  end

  always_comb begin
    strobes.ld1 = inValid;
    strobes.ld2 = validQ[0];
    strobes.ld3 = validQ[1];
  end

  assign outValid = validQ[STAGES-1];
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OPW = 4,
  localparam int RW = 2 * OPW,
  localparam int LOW = OPW / 2,
  localparam int HIGH = OPW - LOW
) (
  input  logic           clk,
  input  stageStrobes_t  strobes,
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  input  logic [OPW-1:0] c,
  output logic [RW-1:0]  result
);
  // stage 1: lower partial products plus addend
  logic [RW-1:0] ppLow [LOW];
  logic [RW-1:0] sum1;
  for (genvar i = 0; i < LOW; i++) begin : g_ppLow
    assign ppLow[i] = b[i] ? (RW'(a) << i) : '0;
  end

  always_comb begin
    sum1 = RW'(c);
    for (int i = 0; i < LOW; i++) sum1 = sum1 + ppLow[i];
  end

  logic [RW-1:0]   s1Sum;
  logic [OPW-1:0]  s1A;
  logic [HIGH-1:0] s1BHi;
  always_ff @(posedge clk) begin
    if (strobes.ld1) begin
      s1Sum <= sum1;
      s1A   <= a;
      s1BHi <= b[OPW-1:LOW];
    end
  end

  // stage 2: upper partial products from the carried copies
  logic [RW-1:0] ppHigh [HIGH];
  logic [RW-1:0] sum2;
  for (genvar j = 0; j < HIGH; j++) begin : g_ppHigh
    assign ppHigh[j] = s1BHi[j] ? (RW'(s1A) << (LOW + j)) : '0;
  end

  always_comb begin
    sum2 = s1Sum;
    for (int j = 0; j < HIGH; j++) sum2 = sum2 + ppHigh[j];
  end

  logic [RW-1:0] s2Sum;
  always_ff @(posedge clk) begin
    if (strobes.ld2) s2Sum <= sum2;
  end

  // stage 3: output register
  logic [RW-1:0] resultQ;
  always_ff @(posedge clk) begin
    if (strobes.ld3) resultQ <= s2Sum;
  end

  assign result = resultQ;
endmodule

// File: rtl/shift_add_mac.sv
module shift_add_mac
  import mac_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  input  logic [OPW-1:0]   c,
  output logic             outValid,
  output logic [2*OPW-1:0] result
);
  stageStrobes_t strobes;

  mac_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  mac_datapath #(.OPW(OPW)) dp_i (
    .clk     (clk),
    .strobes (strobes),
    .a       (a),
    .b       (b),
    .c       (c),
    .result  (result)
  );
endmodule

// File: rtl/shift_add_mac_chk.sv
module shift_add_mac_chk #(
  parameter int OPW = 4,
  localparam int RW = 2 * OPW
) (
  input logic           clk,
  input logic           rst,
  input logic           inValid,
  input logic [OPW-1:0] a,
  input logic [OPW-1:0] b,
  input logic [OPW-1:0] c,
  input logic           outValid,
  input logic [RW-1:0]  result
);
  localparam logic [RW-1:0] MAXV = RW'((2**OPW - 1) * (2**OPW - 1) + (2**OPW - 1));

  // R1 R2
  mac_value_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> result == (RW'($past(a, 3)) * RW'($past(b, 3)) + RW'($past(c, 3))));

  // R4
  valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 3));

  // R5
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> result <= MAXV);
endmodule

bind shift_add_mac shift_add_mac_chk #(.OPW(OPW)) chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .a(a), .b(b), .c(c),
  .outValid(outValid), .result(result)
);

// File: tb/shift_add_mac_tb_top.sv
`timescale 1ns/1ps
module shift_add_mac_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [3:0] a = '0, b = '0, c = '0;
  logic       outValid;
  logic [7:0] result;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic       hv [4];
  logic [3:0] ha [4], hb [4], hc [4];
  string      htag [4];

  always #5 clk = ~clk;

  shift_add_mac dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .a(a), .b(b), .c(c),
    .outValid(outValid), .result(result)
  );

  function automatic logic [7:0] expMac(logic [3:0] x, logic [3:0] y, logic [3:0] z);
    return 8'(x) * 8'(y) + 8'(z);
  endfunction

  // One clock step: check the set due now, then drive the next one
  task automatic step(input logic v, input logic [3:0] xa, input logic [3:0] xb,
                      input logic [3:0] xc, input logic r, input string tag);
    int oi;
    @(negedge clk);
    oi = (cyc + 1) % 4;
    if (cyc >= 1) begin
      checks++;
      if (outValid !== hv[oi]) begin
        fails++;
        $display("FAIL R4/%s outValid=%0b expected=%0b cycle=%0d", htag[oi], outValid, hv[oi], cyc);
      end
      if (hv[oi]) begin
        checks++;
        if (result !== expMac(ha[oi], hb[oi], hc[oi])) begin
          fails++;
          $display("FAIL R1/%s result=%0d expected=%0d (a=%0d b=%0d c=%0d)", htag[oi], result,
                   expMac(ha[oi], hb[oi], hc[oi]), ha[oi], hb[oi], hc[oi]);
        end
      end
    end
    if (r) for (int k = 0; k < 4; k++) begin hv[k] = 1'b0; htag[k] = "R5/R8"; end
    hv[cyc % 4] = v && !r;
    ha[cyc % 4] = xa; hb[cyc % 4] = xb; hc[cyc % 4] = xc;
    htag[cyc % 4] = r ? "R5/R8" : tag;
    rst = r; inValid = v; a = xa; b = xb; c = xc;
    cyc++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, tag);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin hv[k] = 1'b0; ha[k] = '0; hb[k] = '0; hc[k] = '0; htag[k] = "R5"; end
    void'($urandom(32'd1234));
    // reset with random valid traffic that must be discarded (R5)
    for (int k = 0; k < 3; k++) step(1'b1, 4'($urandom), 4'($urandom), 4'($urandom), 1'b1, "R5");
    idle(4, "R5");
    // R6 extreme operands
    step(1'b1, 4'd15, 4'd15, 4'd15, 1'b0, "R6");
    step(1'b1, 4'd0, 4'd0, 4'd0, 1'b0, "R6");
    step(1'b1, 4'd15, 4'd0, 4'd15, 1'b0, "R6");
    step(1'b1, 4'd0, 4'd15, 4'd7, 1'b0, "R6");
    idle(4, "R6");
    // R7 one-hot multiplier
    for (int i = 0; i < 4; i++) step(1'b1, 4'd13, 4'(1 << i), 4'd0, 1'b0, "R7");
    for (int i = 0; i < 4; i++) step(1'b1, 4'd15, 4'(1 << i), 4'd0, 1'b0, "R7");
    idle(4, "R7");
    // R2 single isolated set: valid for exactly one cycle, three clocks later
    step(1'b1, 4'd9, 4'd11, 4'd3, 1'b0, "R2");
    idle(5, "R2");
    // R3 back-to-back random sets
    for (int k = 0; k < 300; k++)
      step(1'b1, 4'($urandom), 4'($urandom), 4'($urandom), 1'b0, "R3");
    // R4 random gaps in valid
    for (int k = 0; k < 300; k++)
      step(1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 1'b0, "R4");
    // R8 reset while sets are in flight
    step(1'b1, 4'd5, 4'd6, 4'd7, 1'b0, "R8");
    step(1'b1, 4'd8, 4'd9, 4'd10, 1'b0, "R8");
    step(1'b1, 4'd1, 4'd2, 4'd3, 1'b1, "R8");
    idle(5, "R8");
    step(1'b1, 4'd12, 4'd12, 4'd12, 1'b0, "R8");
    idle(5, "R8");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule